// File: doc/BRIEF.md
# Scoreboard Issue Hazard Controller

This block is the hazard-tracking core of a dynamically scheduled pipeline. It receives decoded instructions in program order, each carrying an operation class, a destination register and two source registers. It decides, one cycle at a time, when each instruction may enter a functional unit, when that unit may read its operands, and when it may write its result back. It holds no register values, only the bookkeeping needed to enforce true, anti and output dependences and to avoid structural conflicts.

Five functional units are tracked: an integer unit that also serves memory operations, an adder, two multipliers and a divider. Each unit is modelled by a latency counter. Every unit has a status record that holds its destination, its sources, the units that will produce those sources and a ready flag for each source. A table indexed by register names the unit that will write each register next.

The upstream decoder holds `in_valid` and the instruction fields steady while `stall` is high. The execution datapath uses `rd_strobe` to latch operands, and `wr_grant` to drive the register-file write port.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset no unit is busy: `stall`, `iss_grant`, `rd_strobe` and `wr_grant` are all zero while `in_valid` is low.
- R2: Class code 0 goes to unit 0 (integer), 1 to unit 1 (adder), 3 to unit 4 (divider), and 2 to unit 2, or to unit 3 when unit 2 is busy. `iss_grant` is one-hot and marks the receiving unit.
- R3: An instruction whose class has no free unit stalls. It issues in the cycle after the write grant of the unit that frees up.
- R4: An instruction whose destination is already owned by an in-flight instruction stalls. It issues in the cycle after that owner's write grant.
- R5: A source owned by an in-flight producer is read in the cycle after the producer's write grant. This also holds when the consumer issues in the same cycle as that grant.
- R6: A unit whose sources have no pending producer reads its operands in the first cycle after issue, and it reads them only once.
- R7: The write grant comes L+1 cycles after the operand read, where L is 1 for integer, 2 for add, 10 for multiply and 40 for divide, unless the grant is held off by R8 or R9.
- R8: A finished unit is held from writing while another busy unit names its destination as a source that has not yet been read. It writes in the cycle after that read.
- R9: At most one write grant is given per cycle. Among eligible units the lowest index wins, and the others wait.
- R10: `stall` is high only when `in_valid` is high and the instruction cannot issue. With `in_valid` low, nothing issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered for issue |
| in_cls | input | 2 | Operation class: 0 integer/memory, 1 add, 2 multiply, 3 divide |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| stall | output | 1 | Offered instruction cannot issue this cycle |
| iss_grant | output | 5 | One-hot unit receiving the instruction at this edge |
| rd_strobe | output | 5 | Per-unit operand read and execution start |
| wr_grant | output | 5 | Per-unit result write permission |

## Verification
A corrupted owner-table entry or a stale producer tag shows up as an instruction that stalls for ever or issues too early. A lost ready flag freezes a unit before its read strobe, so the bench measures every strobe time against an arithmetically derived cycle and catches the error within one latency window. An error in the anti-dependence hold moves a write grant earlier than the reader's strobe. An error in arbitration or latency shifts a grant by one or more cycles. Either one is visible at the port in the first affected cycle.

// File: rtl/scoreboard_issue.sv
module scoreboard_issue #(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_cls,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  output logic                    stall,
  output logic [4:0]              iss_grant,
  output logic [4:0]              rd_strobe,
  output logic [4:0]              wr_grant
);
  localparam int NFU  = 5;
  localparam int RW   = $clog2(NREG);
  localparam int TW   = 3;
  localparam int LM1  = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
  localparam int LM2  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LMAX = (LM1 > LM2) ? LM1 : LM2;
  localparam int CW   = $clog2(LMAX + 1);
  localparam logic [1:0] PH_OPS = 2'd0, PH_EXE = 2'd1, PH_WB = 2'd2;

  function automatic int unit_lat(input int u);
    case (u)
      0:       return LAT_INT;
      1:       return LAT_ADD;
      2, 3:    return LAT_MUL;
      default: return LAT_DIV;
    endcase
  endfunction

  logic [NFU-1:0]          busy, rj, rk;
  logic [1:0]              ph  [NFU];
  logic [CW-1:0]           cnt [NFU];
  logic [RW-1:0]           fi  [NFU];
  logic [RW-1:0]           fj  [NFU];
  logic [RW-1:0]           fk  [NFU];
  logic [TW-1:0]           qj  [NFU];
  logic [TW-1:0]           qk  [NFU];
  logic [TW-1:0]           owner [NREG];

  logic [NFU-1:0] want, sel, elig, war_blk;
  logic           can_go, wr_any;
  logic [2:0]     wr_u, is_u;
  logic [TW-1:0]  wr_tag, tag1, tag2;

  always_comb begin
    case (in_cls)
      2'd0:    want = 5'b00001;
      2'd1:    want = 5'b00010;
      2'd2:    want = 5'b01100;
      default: want = 5'b10000;
    endcase
    sel       = want & ~busy;
    can_go    = (sel != '0) && (owner[in_dst] == '0);
    stall     = in_valid && !can_go;
    iss_grant = (in_valid && can_go) ? (sel & (~sel + 1'b1)) : '0;
    for (int u = 0; u < NFU; u++) begin
      rd_strobe[u] = busy[u] && ph[u] == PH_OPS && rj[u] && rk[u];
      war_blk[u]   = 1'b0;
      for (int v = 0; v < NFU; v++)
        if (v != u && busy[v] && ((fj[v] == fi[u] && rj[v]) || (fk[v] == fi[u] && rk[v])))
          war_blk[u] = 1'b1;
      elig[u] = busy[u] && ph[u] == PH_WB && !war_blk[u];
    end
    wr_grant = elig & (~elig + 1'b1);
    wr_any   = wr_grant != '0;
    wr_u     = '0;
    is_u     = '0;
    for (int u = 0; u < NFU; u++) begin
      if (wr_grant[u])  wr_u = 3'(u);
      if (iss_grant[u]) is_u = 3'(u);
    end
    wr_tag = wr_any ? TW'(wr_u) + 1'b1 : '0;
    tag1   = (wr_any && owner[in_src1] == wr_tag) ? '0 : owner[in_src1];
    tag2   = (wr_any && owner[in_src2] == wr_tag) ? '0 : owner[in_src2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      rj   <= '0;
      rk   <= '0;
      for (int u = 0; u < NFU; u++) begin
        ph[u]  <= PH_OPS;
        cnt[u] <= '0;
        fi[u]  <= '0;
        fj[u]  <= '0;
        fk[u]  <= '0;
        qj[u]  <= '0;
        qk[u]  <= '0;
      end
      for (int r = 0; r < NREG; r++) owner[r] <= '0;
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (busy[u] && wr_any && qj[u] == wr_tag) begin
          qj[u] <= '0;
          rj[u] <= 1'b1;
        end
        if (busy[u] && wr_any && qk[u] == wr_tag) begin
          qk[u] <= '0;
          rk[u] <= 1'b1;
        end
        if (rd_strobe[u]) begin
          rj[u]  <= 1'b0;
          rk[u]  <= 1'b0;
          ph[u]  <= PH_EXE;
          cnt[u] <= CW'(unit_lat(u) - 1);
        end else if (busy[u] && ph[u] == PH_EXE) begin
          if (cnt[u] == '0) ph[u] <= PH_WB;
          else              cnt[u] <= cnt[u] - 1'b1;
        end
        if (wr_grant[u]) busy[u] <= 1'b0;
        if (iss_grant[u]) begin
          busy[u] <= 1'b1;
          ph[u]   <= PH_OPS;
          fi[u]   <= in_dst;
          fj[u]   <= in_src1;
          fk[u]   <= in_src2;
          qj[u]   <= tag1;
          qk[u]   <= tag2;
          rj[u]   <= tag1 == '0;
          rk[u]   <= tag2 == '0;
        end
      end
      if (wr_any) owner[fi[wr_u]] <= '0;
      if (iss_grant != '0) owner[in_dst] <= TW'(is_u) + 1'b1;
    end
  end

  for (genvar g = 0; g < NFU; g++) begin : g_chk
    AST_WB_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n) wr_grant[g] |=> !busy[g]); // R3
    AST_ISSUE_IDLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n) iss_grant[g] |-> !busy[g]); // R3
    AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n) rd_strobe[g] |=> !rd_strobe[g]); // R6
    AST_NO_EARLY_WB: assert property (@(posedge clk) disable iff (!rst_n) rd_strobe[g] |=> !wr_grant[g]); // R7
  end
  AST_ONE_WB: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_grant)); // R9
  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(iss_grant)); // R2
  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) stall |-> iss_grant == '0); // R10
  AST_QUIET_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> iss_grant == '0 && !stall); // R10
endmodule

// File: tb/tb_scoreboard_issue.sv
module tb_scoreboard_issue;
  logic       clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] in_cls = 0;
  logic [4:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic       stall;
  logic [4:0] iss_grant, rd_strobe, wr_grant;

  scoreboard_issue dut (.*);

  always #4 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int rd_t[5], wr_t[5], rd_n[5];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    for (int u = 0; u < 5; u++) begin
      if (rd_strobe[u]) begin rd_t[u] = cyc; rd_n[u]++; end
      if (wr_grant[u]) wr_t[u] = cyc;
    end

  function automatic int lat_of(input int u);
    case (u) 0: return 1; 1: return 2; 2, 3: return 10; default: return 40; endcase
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr();
    for (int u = 0; u < 5; u++) begin rd_t[u] = -1; wr_t[u] = -1; rd_n[u] = 0; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int c, input int d, input int s1, input int s2,
                      output int unit, output int waited, output int ic);
    in_cls = 2'(c); in_dst = 5'(d); in_src1 = 5'(s1); in_src2 = 5'(s2);
    in_valid = 1; waited = 0; unit = -1;
    while (1) begin
      #1;
      if (!stall) begin
        for (int u = 0; u < 5; u++) if (iss_grant[u]) unit = u;
        break;
      end
      waited++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0;
    ic = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int un, w, ic, a;
    clr();
    idle(2);
    rst_n = 1;
    idle(1);
    #1;
    chk("R1 stall", int'(stall), 0);
    chk("R1 iss", int'(iss_grant), 0);
    chk("R1 rd", int'(rd_strobe), 0);
    chk("R1 wr", int'(wr_grant), 0);
    @(negedge clk);

    for (int c = 0; c < 4; c++) begin
      int exp_u;
      exp_u = (c == 3) ? 4 : (c == 2 ? 2 : c);
      clr();
      send(c, 10 + c, 1, 2, un, w, ic);
      chk("R2 unit", un, exp_u);
      idle(60);
      chk("R6 read after issue", rd_t[exp_u], ic);
      chk("R6 single read", rd_n[exp_u], 1);
      chk("R7 latency", wr_t[exp_u] - rd_t[exp_u], lat_of(exp_u) + 1);
    end

    clr();
    send(2, 20, 1, 2, un, w, ic); chk("R2 mul first", un, 2);
    send(2, 21, 1, 2, un, w, ic); chk("R2 mul second", un, 3); chk("R3 no wait", w, 0);
    send(2, 22, 1, 2, un, w, ic); chk("R3 mul wait", w, 11); chk("R2 mul reuse", un, 2);
    idle(30);

    clr();
    send(3, 23, 1, 2, un, w, ic);
    send(3, 24, 1, 2, un, w, ic);
    chk("R3 div wait", w, 42); chk("R3 div unit", un, 4);
    idle(50);

    clr();
    send(0, 1, 2, 3, un, w, a);
    send(1, 4, 1, 5, un, w, ic);
    idle(10);
    chk("R7 int write", wr_t[0], a + 2);
    chk("R5 RAW read", rd_t[1], wr_t[0] + 1);

    clr();
    send(0, 5, 2, 3, un, w, ic);
    send(1, 5, 6, 7, un, w, ic);
    chk("R4 WAW wait", w, 3);
    idle(10);
    chk("R4 WAW read", rd_t[1], wr_t[0] + 2);

    clr();
    send(2, 0, 2, 4, un, w, ic);
    send(3, 10, 0, 6, un, w, ic);
    send(1, 6, 8, 2, un, w, ic);
    idle(70);
    chk("R5 div read", rd_t[4], wr_t[2] + 1);
    chk("R8 WAR hold", wr_t[1], rd_t[4] + 1);
    chk("R8 held late", int'(wr_t[1] > rd_t[1] + 3), 1);

    clr();
    send(1, 7, 1, 2, un, w, ic);
    send(0, 8, 1, 2, un, w, ic);
    idle(10);
    chk("R9 low index wins", wr_t[0], rd_t[1] + 3);
    chk("R9 loser waits", wr_t[1], rd_t[1] + 4);

    clr();
    send(0, 12, 1, 2, un, w, a);
    idle(2);
    send(1, 13, 12, 3, un, w, ic);
    idle(10);
    chk("R5 same-cycle grant", rd_t[1], wr_t[0] + 1);

    clr();
    send(3, 9, 1, 2, un, w, ic);
    #1;
    chk("R10 idle no stall", int'(stall), 0);
    chk("R10 idle no issue", int'(iss_grant), 0);
    in_cls = 2'd3; in_dst = 5'd11; in_valid = 1;
    #1;
    chk("R10 stall high", int'(stall), 1);
    @(negedge clk);
    in_valid = 0;
    idle(50);
    chk("R10 single div", rd_n[4], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule